// File: doc/BRIEF.md
# Static-Radix Fractional Arithmetic Unit

This unit is the arithmetic datapath of a microcoded engine that runs linear-transform kernels on N-bit two's-complement fractions. No exponent is kept in hardware. The compiler tracks where the radix point of each value sits and encodes the scaling it wants directly in each microinstruction. The unit provides only one-bit steps of that scaling: a halving aligner on either adder input, a halving normalizer on the adder output, and a doubling normalizer on the multiplier output.

Each issued microinstruction carries two operands, a two-bit opcode, the shift-enable flags and a barrel-shift amount. Three engines compute in parallel from these fields:
- an (N+1)-bit adder/subtractor;
- a rounded fractional multiplier;
- an arithmetic right barrel shifter.

The opcode selects one of the three results. The selected result is registered, and a valid flag marks the cycle in which it appears.

Top module: `sfp_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `res_o` = 0 and `res_vld_o` = 0.
- R2: `res_vld_o` equals `issue_i` of the previous clock edge. When `issue_i` is low, `res_o` keeps its value.
- R3: Opcode 2'b00 adds and 2'b01 subtracts (A' − B'). With `post_half_i` set, the result is floor((A' ± B') / 2), computed exactly on N+1 bits so it never overflows.
- R4: With `pre_shift_a_i` (or `pre_shift_b_i`) set, A' = floor(a / 2) (or B' = floor(b / 2)). Otherwise A' = a and B' = b.
- R5: With `post_half_i` clear, the add or subtract result is A' ± B' saturated to the range [−2^(N−1), 2^(N−1)−1].
- R6: Opcode 2'b10 multiplies. With `mul_norm_i` clear, the result is floor((a·b + 2^(N−1)) / 2^N), which is round-half-up on the first discarded bit.
- R7: With `mul_norm_i` set, the product is doubled before rounding. The result is floor((2·a·b + 2^(N−1)) / 2^N), saturated to N bits.
- R8: With `mul_norm_i` set, (−1) × (−1) gives the largest positive fraction, 2^(N−1)−1.
- R9: Opcode 2'b11 returns a arithmetically shifted right by `shift_amt_i` (0 to N−1). Operand b and all shift-enable flags have no effect on this result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Microinstruction issue strobe |
| opcode_i | input | 2 | 00 add, 01 sub, 10 mul, 11 shift right |
| src_a_i | input | DATA_W | Operand a (fraction) |
| src_b_i | input | DATA_W | Operand b (fraction) |
| pre_shift_a_i | input | 1 | Halve operand a before add/sub |
| pre_shift_b_i | input | 1 | Halve operand b before add/sub |
| post_half_i | input | 1 | Halve the (N+1)-bit sum to return to N bits |
| mul_norm_i | input | 1 | Double the product before rounding |
| shift_amt_i | input | $clog2(DATA_W) | Barrel shift distance |
| res_o | output | DATA_W | Registered result |
| res_vld_o | output | 1 | Result valid, one cycle after issue |

## Verification
The assertions check the cycle relations on every clock edge:
- reset clearing the outputs;
- the valid flag tracking the issue strobe;
- the result holding between issues.

They also check a few fixed identities: the saturated (−1)×(−1), zero-distance shifts, and adding zero with halving.

The arithmetic itself is left to the bench scenarios, because it needs an independent model. These cover rounding on the discarded bit, the floor behaviour of each aligner, saturation at both ends, and shift distances out to N−1.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef enum logic [1:0] {
        OPC_ADD = 2'b00,
        OPC_SUB = 2'b01,
        OPC_MUL = 2'b10,
        OPC_SHR = 2'b11
    } sfp_opc_e;

    typedef struct packed {
        logic pre_a;
        logic pre_b;
        logic post_half;
        logic mul_norm;
    } sfp_scale_t;

    localparam int SFP_DEF_W = 16;

endpackage

// File: rtl/sfp_addsub.sv
module sfp_addsub #(
    parameter int DATA_W = 16
) (
    input  logic              sub_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  sfp_pkg::sfp_scale_t scl_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int EW = DATA_W + 1;
    localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [EW-1:0] ext_a, ext_b, al_a, al_b, sum;

    always_comb begin
        ext_a = {a_i[DATA_W-1], a_i};
        ext_b = {b_i[DATA_W-1], b_i};
        al_a  = scl_i.pre_a ? (ext_a >>> 1) : ext_a;
        al_b  = scl_i.pre_b ? (ext_b >>> 1) : ext_b;
        sum   = sub_i ? (al_a - al_b) : (al_a + al_b);
        if (scl_i.post_half)
            y_o = sum[EW-1:1];
        else if (sum[EW-1] != sum[EW-2])
            y_o = sum[EW-1] ? MINV : MAXV;
        else
            y_o = sum[DATA_W-1:0];
    end
endmodule

// File: rtl/sfp_fracmul.sv
module sfp_fracmul #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              norm_i,
    output logic [DATA_W-1:0] y_o
);
    localparam int PW = 2 * DATA_W;
    localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    logic signed [DATA_W-1:0] sa, sb;
    logic signed [PW-1:0]     prod;
    logic signed [PW:0]       scaled;
    logic signed [DATA_W:0]   fld;

    assign sa   = a_i;
    assign sb   = b_i;
    assign prod = sa * sb;

    always_comb begin
        scaled = norm_i ? {prod, 1'b0} : {prod[PW-1], prod};
        fld    = scaled[PW:DATA_W] + {{DATA_W{1'b0}}, scaled[DATA_W-1]};
        if (fld[DATA_W] != fld[DATA_W-1])
            y_o = fld[DATA_W] ? MINV : MAXV;
        else
            y_o = fld[DATA_W-1:0];
    end
endmodule

// File: rtl/sfp_barrel.sv
module sfp_barrel #(
    parameter int DATA_W = 16,
    localparam int SW = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [SW-1:0]     amt_i,
    output logic [DATA_W-1:0] y_o
);
    logic [DATA_W-1:0] stg [SW+1];

    assign stg[0] = a_i;

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int DIST = 1 << k;
        assign stg[k+1] = amt_i[k] ? DATA_W'($signed(stg[k]) >>> DIST) : stg[k];
    end

    assign y_o = stg[SW];
endmodule

// File: rtl/sfp_alu.sv
module sfp_alu #(
    parameter int DATA_W = sfp_pkg::SFP_DEF_W,
    localparam int SW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [1:0]        opcode_i,
    input  logic [DATA_W-1:0] src_a_i,
    input  logic [DATA_W-1:0] src_b_i,
    input  logic              pre_shift_a_i,
    input  logic              pre_shift_b_i,
    input  logic              post_half_i,
    input  logic              mul_norm_i,
    input  logic [SW-1:0]     shift_amt_i,
    output logic [DATA_W-1:0] res_o,
    output logic              res_vld_o
);
    import sfp_pkg::*;

    sfp_opc_e          opc;
    sfp_scale_t        scl;
    logic [DATA_W-1:0] add_y, mul_y, shr_y, sel_y;

    assign opc = sfp_opc_e'(opcode_i);
    assign scl = '{pre_a: pre_shift_a_i, pre_b: pre_shift_b_i,
                   post_half: post_half_i, mul_norm: mul_norm_i};

    sfp_addsub #(.DATA_W(DATA_W)) u_add (
        .sub_i (opc == OPC_SUB),
        .a_i   (src_a_i),
        .b_i   (src_b_i),
        .scl_i (scl),
        .y_o   (add_y)
    );

    sfp_fracmul #(.DATA_W(DATA_W)) u_mul (
        .a_i    (src_a_i),
        .b_i    (src_b_i),
        .norm_i (scl.mul_norm),
        .y_o    (mul_y)
    );

    sfp_barrel #(.DATA_W(DATA_W)) u_shr (
        .a_i   (src_a_i),
        .amt_i (shift_amt_i),
        .y_o   (shr_y)
    );

    always_comb begin
        unique case (opc)
            OPC_ADD, OPC_SUB: sel_y = add_y;
            OPC_MUL:          sel_y = mul_y;
            default:          sel_y = shr_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_o     <= '0;
            res_vld_o <= 1'b0;
        end else begin
            res_vld_o <= issue_i;
            if (issue_i) res_o <= sel_y;
        end
    end
endmodule

// File: rtl/sfp_alu_chk.sv
module sfp_alu_chk #(
    parameter int DATA_W = 16,
    localparam int SW = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              issue_i,
    input logic [1:0]        opcode_i,
    input logic [DATA_W-1:0] src_a_i,
    input logic [DATA_W-1:0] src_b_i,
    input logic              pre_shift_a_i,
    input logic              pre_shift_b_i,
    input logic              post_half_i,
    input logic              mul_norm_i,
    input logic [SW-1:0]     shift_amt_i,
    input logic [DATA_W-1:0] res_o,
    input logic              res_vld_o
);
    localparam logic [DATA_W-1:0] MAXV = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res_o == '0 && !res_vld_o));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (res_vld_o == $past(issue_i)));

    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> $stable(res_o));

    assert_add_zero_half_R3: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i == 2'b00 && post_half_i && !pre_shift_a_i
         && !pre_shift_b_i && src_b_i == '0)
        |=> (res_o == DATA_W'($signed($past(src_a_i)) >>> 1)));

    assert_minus_one_sq_R8: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i == 2'b10 && mul_norm_i && src_a_i == MINV && src_b_i == MINV)
        |=> (res_o == MAXV));

    assert_shift_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (issue_i && opcode_i == 2'b11 && shift_amt_i == '0)
        |=> (res_o == $past(src_a_i)));
endmodule

bind sfp_alu sfp_alu_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/sfp_alu_tb.sv
module sfp_alu_tb_top;
    localparam int N  = 16;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          issue_i = 1'b0;
    logic [1:0]    opcode_i = 2'b00;
    logic [N-1:0]  src_a_i = '0, src_b_i = '0;
    logic          pre_shift_a_i = 1'b0, pre_shift_b_i = 1'b0;
    logic          post_half_i = 1'b0, mul_norm_i = 1'b0;
    logic [SW-1:0] shift_amt_i = '0;
    logic [N-1:0]  res_o;
    logic          res_vld_o;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    sfp_alu #(.DATA_W(N)) dut_i (.*);

    function automatic longint sat(longint v);
        longint hi = (longint'(1) <<< (N-1)) - 1;
        longint lo = -(longint'(1) <<< (N-1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint sx(logic [N-1:0] v);
        return longint'($signed(v));
    endfunction

    function automatic logic [N-1:0] m_add(logic [N-1:0] a, logic [N-1:0] b, bit sub,
                                           bit pa, bit pb, bit ph);
        longint ea = pa ? (sx(a) >>> 1) : sx(a);
        longint eb = pb ? (sx(b) >>> 1) : sx(b);
        longint s  = sub ? ea - eb : ea + eb;
        return N'(ph ? (s >>> 1) : sat(s));
    endfunction

    function automatic logic [N-1:0] m_mul(logic [N-1:0] a, logic [N-1:0] b, bit nm);
        longint p = sx(a) * sx(b);
        if (nm) p = p * 2;
        return N'(sat((p + (longint'(1) <<< (N-1))) >>> N));
    endfunction

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // issue one microinstruction, then check result and valid one edge later
    task automatic run(string req, logic [1:0] op, logic [N-1:0] a, logic [N-1:0] b,
                       bit pa, bit pb, bit ph, bit nm, logic [SW-1:0] sh,
                       logic [N-1:0] exp);
        @(negedge clk);
        issue_i = 1'b1; opcode_i = op; src_a_i = a; src_b_i = b;
        pre_shift_a_i = pa; pre_shift_b_i = pb; post_half_i = ph; mul_norm_i = nm;
        shift_amt_i = sh;
        @(negedge clk);
        issue_i = 1'b0;
        check(req, res_o, exp);
        check({req, " valid"}, {{(N-1){1'b0}}, res_vld_o}, {{(N-1){1'b0}}, 1'b1});
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 result", res_o, '0);
        check("R1 valid", {{(N-1){1'b0}}, res_vld_o}, '0);
    endtask

    task automatic t_add();
        run("R3 add half", 2'b00, 16'h4000, 16'h2000, 0, 0, 1, 0, 0, m_add(16'h4000, 16'h2000, 0, 0, 0, 1));
        run("R3 add half max", 2'b00, 16'h7FFF, 16'h7FFF, 0, 0, 1, 0, 0, 16'h7FFF);
        run("R3 sub half", 2'b01, 16'h8000, 16'h7FFF, 0, 0, 1, 0, 0, 16'h8000);
        run("R3 sub odd", 2'b01, 16'h0003, 16'h0000, 0, 0, 1, 0, 0, 16'h0001);
    endtask

    task automatic t_align();
        run("R4 align a", 2'b00, 16'hFFFF, 16'h0001, 1, 0, 0, 0, 0, m_add(16'hFFFF, 16'h0001, 0, 1, 0, 0));
        run("R4 align b", 2'b01, 16'h1000, 16'h3001, 0, 1, 0, 0, 0, m_add(16'h1000, 16'h3001, 1, 0, 1, 0));
        run("R4 align both", 2'b00, 16'h8000, 16'h8000, 1, 1, 0, 0, 0, 16'h8000);
    endtask

    task automatic t_sat();
        run("R5 sat pos", 2'b00, 16'h6000, 16'h6000, 0, 0, 0, 0, 0, 16'h7FFF);
        run("R5 sat neg", 2'b01, 16'h8000, 16'h0001, 0, 0, 0, 0, 0, 16'h8000);
        run("R5 no sat", 2'b00, 16'h1234, 16'hF000, 0, 0, 0, 0, 0, 16'h0234);
    endtask

    task automatic t_mul();
        run("R6 half*half", 2'b10, 16'h4000, 16'h4000, 0, 0, 0, 0, 0, 16'h1000);
        run("R6 round up", 2'b10, 16'h0001, 16'h8000, 0, 0, 0, 0, 0, m_mul(16'h0001, 16'h8000, 0));
        run("R6 mixed", 2'b10, 16'h5A5A, 16'hC3C3, 0, 0, 0, 0, 0, m_mul(16'h5A5A, 16'hC3C3, 0));
        run("R6 -1*-1", 2'b10, 16'h8000, 16'h8000, 0, 0, 0, 0, 0, 16'h4000);
    endtask

    task automatic t_mulnorm();
        run("R7 half*half", 2'b10, 16'h4000, 16'h4000, 0, 0, 0, 1, 0, 16'h2000);
        run("R7 round", 2'b10, 16'h0003, 16'h4001, 0, 0, 0, 1, 0, m_mul(16'h0003, 16'h4001, 1));
        run("R7 neg", 2'b10, 16'h7FFF, 16'h8001, 0, 0, 0, 1, 0, m_mul(16'h7FFF, 16'h8001, 1));
        run("R8 -1*-1 sat", 2'b10, 16'h8000, 16'h8000, 0, 0, 0, 1, 0, 16'h7FFF);
    endtask

    task automatic t_shift();
        run("R9 by 0", 2'b11, 16'h9abc, 16'hFFFF, 1, 1, 1, 1, 4'd0, 16'h9abc);
        run("R9 by 3", 2'b11, 16'h9abc, 16'h1234, 1, 0, 1, 0, 4'd3, 16'hF357);
        run("R9 by 15 neg", 2'b11, 16'h8000, 16'h0000, 0, 0, 0, 0, 4'd15, 16'hFFFF);
        run("R9 by 15 pos", 2'b11, 16'h7FFF, 16'h5555, 0, 1, 0, 1, 4'd15, 16'h0000);
    endtask

    task automatic t_hold();
        logic [N-1:0] kept;
        run("R2 setup", 2'b00, 16'h0100, 16'h0200, 0, 0, 0, 0, 0, 16'h0300);
        kept = res_o;
        src_a_i = 16'h7777; opcode_i = 2'b10; src_b_i = 16'h7777;
        repeat (2) @(negedge clk);
        check("R2 hold", res_o, kept);
        check("R2 idle valid", {{(N-1){1'b0}}, res_vld_o}, '0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst = 1'b0;
        t_add();
        t_align();
        t_sat();
        t_mul();
        t_mulnorm();
        t_shift();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule